// File: doc/BRIEF.md
# PCI Configuration Access Window Decoder

This block is the front end of a host bridge. A CPU issues 32-bit memory-mapped accesses into a 16 MB register window. The block looks at the top two offset bits of each access and handles it in one of three ways. It can load or return the configuration address register. It can perform a type-0 configuration data access to one of the attached configuration-space devices. Otherwise it forwards the access to I/O space. The configuration address is kept in the opposite byte order from the CPU bus. The target device is found from a one-hot select field held in that register.

On the device side, configuration-space devices sit behind a simple register port: a device number, a register number, read and write strobes, and read data that is valid in the same cycle. A presence vector tells the block which device slots are populated. A configuration write narrower than a dword, or not aligned to one, becomes a read, a byte merge and a write-back. I/O accesses are offered to the I/O side, which claims them or not in the same cycle.

The CPU side is a valid/ready request channel with a response pulse. `req_ready` is high only while the block is idle, so a request held with `req_valid` waits, and the caller is back-pressured for the whole access. Each accepted request produces exactly one `rsp_valid` pulse, one cycle long. The response cannot be stalled.

Top module: `cfg_window_decoder`

## Requirements
- R1: Offset bits [23:22] select the function: 2 is the configuration address register, 3 is configuration data, and 0 or 1 is an I/O access that drives `io_rd`/`io_wr` with the offset, size and write data passed through unchanged.
- R2: A write to the configuration address register stores the byte-reversed write data, whatever the size. A read returns the stored value byte-reversed again, so a write followed by a read returns the written word.
- R3: When bit 0 of the stored configuration address is 1 (type 1), a configuration data read returns 0xFFFFFFFF and a write issues no device strobe.
- R4: The select field is stored address bits [31:11]. If it does not have exactly one bit set (this includes the all-zero value after reset), a data read returns 0xFFFFFFFF and a write issues no strobe.
- R5: For a valid select, `cfg_dev` equals the index of the set bit plus 11, and `cfg_reg` equals stored address bits [7:2].
- R6: If `dev_present` at the set bit's index is 0, a data read returns 0xFFFFFFFF and a write issues no strobe.
- R7: A configuration write with size 4 and offset[1:0]=0 issues exactly one `cfg_wr` and no `cfg_rd`, with `cfg_wdata` equal to the byte-reversed write data.
- R8: Any other configuration write (size 1 or 2, or nonzero offset[1:0]) issues one `cfg_rd` and then one `cfg_wr` in the following cycle. The merge places CPU byte i (most significant first within the `req_size`-byte value right-justified in `req_wdata`) into register byte offset+i when offset+i is below 4, and keeps all other bytes.
- R9: `req_size` counts bytes (1, 2 or 4). A configuration data read returns a right-justified value whose byte i, most significant first, is register byte offset+i, with 0 for positions at or beyond 4.
- R10: An I/O read returns `io_rdata` when `io_claim` is 1 and 0 when it is 0.
- R11: After reset `req_ready` is 1 and `rsp_valid` is 0. `req_ready` is 0 from acceptance until the access ends. Every accepted request gives exactly one `rsp_valid` pulse, one cycle long: 2 cycles after acceptance, or 3 for a merged write. Writes respond with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | 24 | Byte offset inside the window |
| req_size | input | 3 | Access size in bytes (1, 2, 4) |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| cfg_rd | output | 1 | Configuration register read strobe |
| cfg_wr | output | 1 | Configuration register write strobe |
| cfg_dev | output | 5 | Device number |
| cfg_reg | output | 6 | Register (dword) number |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, same cycle |
| dev_present | input | 21 | Populated slot per select bit |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_addr | output | 24 | I/O offset |
| io_size | output | 3 | I/O size in bytes |
| io_wdata | output | 32 | I/O write data |
| io_rdata | input | 32 | I/O read data, same cycle |
| io_claim | input | 1 | I/O side accepts the access |

## Verification
The assertions take three things for granted. The first is that `dev_present`, `cfg_rdata`, `io_rdata` and `io_claim` answer in the same cycle as the strobe. The second is that the presence vector does not change during an access. The third is that `req_size` is only ever 1, 2 or 4. The bench holds to this by modelling every device and the I/O side as combinational lookups. It fixes the presence vector for the whole run and sweeps only the three legal sizes across all four byte offsets. A new request is issued only after the previous response pulse.

// File: rtl/cfgw_pkg.sv
`timescale 1ns/1ps
package cfgw_pkg;
  typedef enum logic [1:0] {FN_IO = 2'd0, FN_CADDR = 2'd1, FN_CDATA = 2'd2} fn_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_EXEC = 2'd1, ST_MERGE = 2'd2} st_e;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/cfgw_addr_decode.sv
`timescale 1ns/1ps
module cfgw_addr_decode
  import cfgw_pkg::*;
#(
  parameter int OFS_W = 24
) (
  input  logic [OFS_W-1:0] offset,
  output fn_e              fn
);
  localparam int SEL_HI = OFS_W - 1;

  always_comb begin
    unique case (offset[SEL_HI -: 2])
      2'd2:    fn = FN_CADDR;
      2'd3:    fn = FN_CDATA;
      default: fn = FN_IO;
    endcase
  end
endmodule

// File: rtl/cfgw_idsel_decode.sv
`timescale 1ns/1ps
module cfgw_idsel_decode #(
  parameter int IDSEL_W = 21,
  parameter int IDX_W   = $clog2(IDSEL_W)
) (
  input  logic [IDSEL_W-1:0] idsel,
  output logic               single,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    single = $onehot(idsel);
    idx    = '0;
    for (int i = 0; i < IDSEL_W; i++) begin
      if (idsel[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/cfgw_lane_merge.sv
`timescale 1ns/1ps
module cfgw_lane_merge #(
  parameter int DW = 32,
  parameter int NB = DW / 8
) (
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [1:0]    off,
  input  logic [2:0]    size,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] extracted
);
  always_comb begin
    merged    = reg_val;
    extracted = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < int'(size)) begin
        extracted = extracted << 8;
        if (int'(off) + i < NB) begin
          extracted[7:0] = reg_val[8*(int'(off)+i) +: 8];
          merged[8*(int'(off)+i) +: 8] = cpu_wdata[8*(int'(size)-1-i) +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/cfg_window_decoder.sv
`timescale 1ns/1ps
module cfg_window_decoder
  import cfgw_pkg::*;
#(
  parameter int OFS_W    = 24,
  parameter int IDSEL_W  = 21,
  parameter int DEV_BASE = 11,
  parameter int DEV_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [OFS_W-1:0]   req_offset,
  input  logic [2:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               cfg_rd,
  output logic               cfg_wr,
  output logic [DEV_W-1:0]   cfg_dev,
  output logic [5:0]         cfg_reg,
  output logic [31:0]        cfg_wdata,
  input  logic [31:0]        cfg_rdata,
  input  logic [IDSEL_W-1:0] dev_present,
  output logic               io_rd,
  output logic               io_wr,
  output logic [OFS_W-1:0]   io_addr,
  output logic [2:0]         io_size,
  output logic [31:0]        io_wdata,
  input  logic [31:0]        io_rdata,
  input  logic               io_claim
);
  localparam int IDX_W   = $clog2(IDSEL_W);
  localparam int SEL_LSB = 11;

  st_e               state;
  fn_e               fn;
  logic              r_write;
  logic [OFS_W-1:0]  r_ofs;
  logic [2:0]        r_size;
  logic [31:0]       r_wdata;
  logic [31:0]       caddr;
  logic [31:0]       held;
  logic [IDSEL_W-1:0] idsel;
  logic              single;
  logic [IDX_W-1:0]  idx;
  logic              cfg_ok;
  logic              aligned;
  logic              in_exec_data;
  logic [31:0]       lane_src;
  logic [31:0]       merged;
  logic [31:0]       extracted;
  logic              unused_caddr_bits;

  cfgw_addr_decode #(.OFS_W(OFS_W)) u_dec (.offset(r_ofs), .fn(fn));

  assign idsel = caddr[SEL_LSB +: IDSEL_W];
  cfgw_idsel_decode #(.IDSEL_W(IDSEL_W)) u_sel (.idsel(idsel), .single(single), .idx(idx));

  assign lane_src = (state == ST_MERGE) ? held : cfg_rdata;
  cfgw_lane_merge u_lane (
    .reg_val(lane_src), .cpu_wdata(r_wdata), .off(r_ofs[1:0]), .size(r_size),
    .merged(merged), .extracted(extracted)
  );

  assign unused_caddr_bits = ^{caddr[10:8], caddr[1]};

  assign cfg_ok       = !caddr[0] && single && dev_present[idx];
  assign aligned      = (r_size == 3'd4) && (r_ofs[1:0] == 2'd0);
  assign in_exec_data = (state == ST_EXEC) && (fn == FN_CDATA) && cfg_ok;

  assign req_ready = (state == ST_IDLE);
  assign cfg_dev   = DEV_W'(idx) + DEV_W'(DEV_BASE);
  assign cfg_reg   = caddr[7:2];
  assign cfg_rd    = in_exec_data && (!r_write || !aligned);
  assign cfg_wr    = (in_exec_data && r_write && aligned) || (state == ST_MERGE);
  assign cfg_wdata = aligned ? swap32(r_wdata) : merged;

  assign io_rd    = (state == ST_EXEC) && (fn == FN_IO) && !r_write;
  assign io_wr    = (state == ST_EXEC) && (fn == FN_IO) && r_write;
  assign io_addr  = r_ofs;
  assign io_size  = r_size;
  assign io_wdata = r_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      caddr     <= '0;
      held      <= '0;
      r_write   <= 1'b0;
      r_ofs     <= '0;
      r_size    <= '0;
      r_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            r_write <= req_write;
            r_ofs   <= req_offset;
            r_size  <= req_size;
            r_wdata <= req_wdata;
            state   <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
          unique case (fn)
            FN_CADDR: begin
              if (r_write) caddr <= swap32(r_wdata);
              else         rsp_rdata <= swap32(caddr);
            end
            FN_CDATA: begin
              if (!cfg_ok) begin
                if (!r_write) rsp_rdata <= '1;
              end else if (!r_write) begin
                rsp_rdata <= extracted;
              end else if (!aligned) begin
                held      <= cfg_rdata;
                rsp_valid <= 1'b0;
                state     <= ST_MERGE;
              end
            end
            default: begin
              if (!r_write && io_claim) rsp_rdata <= io_rdata;
            end
          endcase
        end
        ST_MERGE: begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_no_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr || io_rd || io_wr) |-> !req_ready);
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rd && cfg_wr));
  p_merge_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MERGE) |-> $past(cfg_rd));
  p_type1_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> !caddr[0]);
  p_onehot_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> $onehot(idsel));
  p_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> dev_present[idx]);
  p_idx_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> idsel[idx]);
  p_io_cfg_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> !(cfg_rd || cfg_wr));
endmodule

// File: tb/cfg_window_decoder_tb.sv
`timescale 1ns/1ps
module cfg_window_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_offset = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cfg_rd, cfg_wr;
  logic [4:0]  cfg_dev;
  logic [5:0]  cfg_reg;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [20:0] dev_present = 21'h15_A5B3;
  logic        io_rd, io_wr, io_claim;
  logic [23:0] io_addr;
  logic [2:0]  io_size;
  logic [31:0] io_wdata, io_rdata;

  cfg_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_dev(cfg_dev), .cfg_reg(cfg_reg),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_present(dev_present),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_claim(io_claim)
  );

  logic [31:0] dev_mem [0:20][0:63];
  logic [31:0] exp_mem [0:20][0:63];
  int n_rd = 0, n_wr = 0, n_io = 0;
  logic [4:0]  last_dev;
  logic [5:0]  last_reg;
  logic [23:0] last_io_addr;
  logic [2:0]  last_io_size;
  logic [31:0] last_io_wdata;
  int checks = 0, bad = 0;
  bit done = 0;

  always_comb begin
    cfg_rdata = 32'hDEAD_BEEF;
    if (cfg_dev >= 5'd11 && cfg_dev <= 5'd31 && int'(cfg_dev) - 11 < 21)
      cfg_rdata = dev_mem[int'(cfg_dev) - 11][cfg_reg];
  end
  assign io_claim = (io_addr[15:0] < 16'h1000);
  assign io_rdata = {8'hA5, io_addr};

  always @(posedge clk) begin
    if (cfg_rd) n_rd <= n_rd + 1;
    if (cfg_wr) begin
      n_wr <= n_wr + 1;
      dev_mem[int'(cfg_dev) - 11][cfg_reg] <= cfg_wdata;
    end
    if (cfg_rd || cfg_wr) begin last_dev <= cfg_dev; last_reg <= cfg_reg; end
    if (io_rd || io_wr) begin
      n_io <= n_io + 1;
      last_io_addr <= io_addr; last_io_size <= io_size; last_io_wdata <= io_wdata;
    end
  end

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] rd_ext(input logic [31:0] r, input int off, input int sz);
    logic [31:0] v = 0;
    for (int i = 0; i < sz; i++) begin
      v = v << 8;
      if (off + i < 4) v = v | ((r >> (8 * (off + i))) & 32'hFF);
    end
    return v;
  endfunction

  function automatic logic [31:0] wr_mrg(input logic [31:0] r, input logic [31:0] wd,
                                         input int off, input int sz);
    logic [31:0] v = r;
    for (int i = 0; i < sz; i++) begin
      if (off + i < 4) begin
        v = v & ~(32'hFF << (8 * (off + i)));
        v = v | (((wd >> (8 * (sz - 1 - i))) & 32'hFF) << (8 * (off + i)));
      end
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  logic [31:0] rdat;
  int d_rd, d_wr, d_io, lat;

  task automatic do_req(input bit wr, input logic [23:0] ofs, input logic [2:0] sz,
                        input logic [31:0] wd);
    int rd0 = n_rd, wr0 = n_wr, io0 = n_io;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy ready", {31'd0, req_ready}, 32'd0);
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    rdat = rsp_rdata;
    @(negedge clk);
    chk("R11 pulse width", {31'd0, rsp_valid}, 32'd0);
    d_rd = n_rd - rd0; d_wr = n_wr - wr0; d_io = n_io - io0;
  endtask

  task automatic set_ca(input logic [31:0] v);
    do_req(1'b1, 24'h800000, 3'd4, sw(v));
  endtask

  function automatic logic [31:0] ca_of(input int idx, input int r);
    return (32'd1 << (11 + idx)) | (32'(r) << 2);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 21; d++)
      for (int r = 0; r < 64; r++) begin
        dev_mem[d][r] = 32'h5A00_0000 ^ (32'(d) * 32'h0101_0101) ^ (32'(r) * 32'h0001_0203);
        exp_mem[d][r] = dev_mem[d][r];
      end
    repeat (3) @(negedge clk);
    chk("R11 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R11 reset rsp", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;

    do_req(1'b0, 24'hC00000, 3'd4, 0);
    chk("R4 zero select after reset", rdat, 32'hFFFF_FFFF);
    chk("R4 no strobe", 32'(d_rd + d_wr), 0);

    begin
      logic [31:0] vals [4] = '{32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF, 32'hA5C3_0F81};
      for (int k = 0; k < 4; k++) begin
        do_req(1'b1, 24'h800004, 3'(k % 2 + 1), vals[k]);
        chk("R11 write latency", 32'(lat), 32'd2);
        do_req(1'b0, 24'h800000, 3'd4, 0);
        chk("R2 caddr readback", rdat, vals[k]);
        chk("R11 read latency", 32'(lat), 32'd2);
      end
    end

    for (int idx = 0; idx < 21; idx++) begin
      int regs [3] = '{0, 5, 63};
      for (int ri = 0; ri < 3; ri++) begin
        set_ca(ca_of(idx, regs[ri]));
        for (int sz = 1; sz <= 4; sz = sz * 2)
          for (int off = 0; off < 4; off++) begin
            do_req(1'b0, 24'hC00000 + 24'(off), 3'(sz), 0);
            if (dev_present[idx]) begin
              chk("R9 read lanes", rdat, rd_ext(exp_mem[idx][regs[ri]], off, sz));
              chk("R5 dev number", 32'(last_dev), 32'(idx + 11));
              chk("R5 reg number", 32'(last_reg), 32'(regs[ri]));
              chk("R9 one read", 32'(d_rd), 1);
            end else begin
              chk("R6 absent read", rdat, 32'hFFFF_FFFF);
              chk("R6 absent no strobe", 32'(d_rd + d_wr), 0);
            end
          end
      end
    end

    for (int idx = 0; idx < 21; idx++) begin
      if (!dev_present[idx]) continue;
      set_ca(ca_of(idx, 9));
      for (int sz = 1; sz <= 4; sz = sz * 2)
        for (int off = 0; off < 4; off++) begin
          logic [31:0] wd = 32'h8C4E_2B17 ^ (32'(idx) << 8) ^ 32'(off * 7 + sz);
          do_req(1'b1, 24'hC00000 + 24'(off), 3'(sz), wd);
          exp_mem[idx][9] = wr_mrg(exp_mem[idx][9], wd, off, sz);
          if (sz == 4 && off == 0) begin
            chk("R7 aligned no read", 32'(d_rd), 0);
            chk("R7 aligned one write", 32'(d_wr), 1);
            chk("R7 latency", 32'(lat), 2);
          end else begin
            chk("R8 merge read", 32'(d_rd), 1);
            chk("R8 merge write", 32'(d_wr), 1);
            chk("R8 latency", 32'(lat), 3);
          end
          chk("R11 write rsp data", rdat, 0);
          chk("R8 stored value", dev_mem[idx][9], exp_mem[idx][9]);
          do_req(1'b0, 24'hC00000, 3'd4, 0);
          chk("R7 readback", rdat, sw(exp_mem[idx][9]));
        end
    end

    set_ca(ca_of(0, 9) | 32'd1);
    do_req(1'b0, 24'hC00000, 3'd4, 0);
    chk("R3 type1 read", rdat, 32'hFFFF_FFFF);
    chk("R3 type1 no strobe", 32'(d_rd + d_wr), 0);
    do_req(1'b1, 24'hC00000, 3'd4, 32'h1111_2222);
    chk("R3 type1 write dropped", 32'(d_rd + d_wr), 0);
    chk("R3 mem unchanged", dev_mem[0][9], exp_mem[0][9]);

    set_ca(ca_of(0, 9) | ca_of(4, 9));
    do_req(1'b0, 24'hC00000, 3'd4, 0);
    chk("R4 two bits read", rdat, 32'hFFFF_FFFF);
    do_req(1'b1, 24'hC00000, 3'd2, 32'h3333);
    chk("R4 two bits write dropped", 32'(d_rd + d_wr), 0);

    set_ca(ca_of(2, 9));
    do_req(1'b1, 24'hC00001, 3'd1, 32'h77);
    chk("R6 absent write no strobe", 32'(d_rd + d_wr), 0);
    chk("R6 absent mem unchanged", dev_mem[2][9], exp_mem[2][9]);

    begin
      logic [23:0] ios [4] = '{24'h000010, 24'h400FFC, 24'h3F2000, 24'h7FFFFE};
      for (int k = 0; k < 4; k++) begin
        do_req(1'b0, ios[k], 3'd2, 0);
        chk("R1 io read strobe", 32'(d_io + d_rd + d_wr), 1);
        chk("R1 io addr", 32'(last_io_addr), 32'(ios[k]));
        chk("R1 io size", 32'(last_io_size), 2);
        chk("R10 io read data", rdat, (ios[k][15:0] < 16'h1000) ? {8'hA5, ios[k]} : 32'd0);
        do_req(1'b1, ios[k], 3'd4, 32'hCAFE_0000 + 32'(k));
        chk("R1 io write strobe", 32'(d_io), 1);
        chk("R1 io wdata", last_io_wdata, 32'hCAFE_0000 + 32'(k));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule